// File: doc/BRIEF.md
# Burst Instruction Fetch Sequencer

This block reads variable-length script instructions out of memory on behalf of a DMA engine. It talks to memory through a simple bus-master handshake. It raises a request, waits for a grant, and collects one 32-bit word per data-valid strobe. It decides how many words to read in each bus ownership. That choice depends on a burst setting, a prefetch-enable input that cancels bursting, and the instruction class, which is decoded from the first word. The words of each instruction are assembled into a wide word. That word is offered to the consumer with a valid/ready handshake.

Fetching begins in one of two ways. With automatic start, the first write to the instruction pointer starts it. With manual start, that write only loads the pointer, and fetching begins on a separate start pulse. Once started, the sequencer walks forward through memory one instruction after another.

The state machine has five states:

- `ST_IDLE`: halted.
- `ST_REQ`: request raised, waiting for grant.
- `ST_XFER`: granted, collecting beats.
- `ST_GAP`: request dropped for one cycle between two ownerships of the same instruction.
- `ST_PRESENT`: instruction offered.

The transitions are:

- IDLE→REQ when the run flag is set.
- REQ→XFER on grant.
- XFER→GAP on the last beat of an ownership when words are still missing.
- XFER→PRESENT on the last beat of the instruction.
- GAP→REQ unconditionally.
- PRESENT→REQ when the consumer accepts.

Top module: `instr_fetch_seq`

## Requirements
- R1: With manual start clear and the sequencer halted, a pointer write loads the pointer and starts it: `bus_req` is low after the write's clock edge and high after the next one.
- R2: With manual start set, a pointer write only loads the pointer and `bus_req` stays low. A one-cycle `start_set` pulse then starts fetching at the loaded pointer, with `bus_req` high on the second edge after the pulse.
- R3: Burst mode is `cfg_burst_en`=1 and `cfg_prefetch_en`=0. In burst mode the first two words of every instruction are read in one ownership of two beats.
- R4: The class of an instruction is read from bits [31:30] of its first word. The length is reported on `ins_len`, as follows:
  - 00: plain, 2 words.
  - 01: indirect, 3 words.
  - 10: memory move, 3 words.
  - 11: table indirect, 4 words.
- R5: In burst mode, the third word of classes 01 and 10 is read in a separate later ownership of one beat. Words three and four of class 11 are read together in a second ownership of two beats.
- R6: Outside burst mode (burst clear, or prefetch-enable set), every word is read in its own one-beat ownership, with `bus_req` low for at least one cycle between ownerships.
- R7: The first beat of an instruction reads at the loaded pointer. `bus_addr` then advances by 4 per word received, continuing across instruction boundaries.
- R8: `bus_req` stays high until `bus_gnt`. A beat completes only on a cycle with `bus_rd_valid` high. `bus_req` is low on the cycle after the last beat of an ownership.
- R9: When the last word arrives, `ins_valid` rises. Word k is placed at `ins_data[32k+31:32k]`, and unused slots are zero. `ins_valid`, `ins_data` and `ins_len` hold with `bus_req` low until `ins_ready`. The next instruction is fetched after the consumer accepts.
- R10: Pointer writes while the sequencer is running are ignored. Fetching continues at the sequential address.
- R11: After reset, `bus_req` and `ins_valid` are low and the sequencer is halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_burst_en | input | 1 | Group words into bursts |
| cfg_prefetch_en | input | 1 | Prefetch active; cancels bursting |
| cfg_manual_start | input | 1 | Pointer write does not start fetching |
| ptr_wr_en | input | 1 | Pointer write strobe |
| ptr_wr_data | input | AW | Pointer write value (byte address) |
| start_set | input | 1 | Start pulse for manual mode |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | AW | Read address of the current beat |
| bus_rd_valid | input | 1 | Read data strobe, completes one beat |
| bus_rd_data | input | DW | Read data word |
| ins_valid | output | 1 | Assembled instruction available |
| ins_ready | input | 1 | Consumer accepts the instruction |
| ins_len | output | 3 | Words in the instruction |
| ins_data | output | 4*DW | Assembled instruction, word 0 in the low bits |

## Verification
The bench builds the block with its default AW=32 and DW=32. With these values the class field sits at bits [31:30] of each word, and memory words can be derived from their own 32-bit address. The bench's memory model therefore predicts every assembled word and every beat address without help from the design. Vectors cover all four classes under burst, non-burst and prefetch-cancelled settings. They are run with grant latencies of 0 to 2 cycles, with and without one-cycle gaps in the data strobe, so that the ownership grouping, the request drop and the address step are checked under each pattern. Directed runs cover the start timing in both start modes, a long grant wait, a consumer that stalls, and a pointer write during a run.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

    localparam int IFS_MAX_DW = 4;
    localparam int IFS_CNT_W  = $clog2(IFS_MAX_DW + 1);
    localparam int IFS_BEAT_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_REQ     = 3'd1,
        ST_XFER    = 3'd2,
        ST_GAP     = 3'd3,
        ST_PRESENT = 3'd4
    } ifs_state_e;

    typedef enum logic [1:0] {
        KIND_PLAIN    = 2'b00,
        KIND_INDIRECT = 2'b01,
        KIND_MEMMOVE  = 2'b10,
        KIND_TABLE    = 2'b11
    } ifs_kind_e;

    function automatic logic [IFS_CNT_W-1:0] ifs_total_dw(input ifs_kind_e k);
        logic [IFS_CNT_W-1:0] n;
        unique case (k)
            KIND_PLAIN:    n = IFS_CNT_W'(2);
            KIND_INDIRECT: n = IFS_CNT_W'(3);
            KIND_MEMMOVE:  n = IFS_CNT_W'(3);
            KIND_TABLE:    n = IFS_CNT_W'(4);
            default:       n = IFS_CNT_W'(2);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ifs_start_ctrl.sv
module ifs_start_ctrl #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          manual_mode,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          start_pulse,
    input  logic          advance,
    output logic [AW-1:0] ptr,
    output logic          running
);

    // Pointer and run flag: writes land only while halted.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr     <= '0;
            running <= 1'b0;
        end else if (!running) begin
            if (wr_en) begin
                ptr <= wr_addr;
            end
            if ((wr_en && !manual_mode) || start_pulse) begin
                running <= 1'b1;
            end
        end else if (advance) begin
            ptr <= ptr + AW'(STEP);
        end
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        running && advance |=> ptr == $past(ptr) + AW'(STEP)); // R7

    AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !running && manual_mode && !start_pulse |=> !running); // R2

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running); // R10

    AST_PTR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        running && !advance |=> $stable(ptr)); // R10

endmodule

// File: rtl/ifs_burst_plan.sv
module ifs_burst_plan
    import ifs_pkg::*;
#(
    parameter int PAIR = 2
) (
    input  logic                  burst_mode,
    input  logic [IFS_CNT_W-1:0]  dw_idx,
    input  ifs_kind_e             kind,
    output logic [IFS_BEAT_W-1:0] beats,
    output logic [IFS_CNT_W-1:0]  total
);

    // Beats for the ownership that starts at word dw_idx.
    always_comb begin
        total = ifs_total_dw(kind);
        beats = IFS_BEAT_W'(1);
        if (burst_mode) begin
            if (dw_idx == '0) begin
                beats = IFS_BEAT_W'(PAIR);
            end else if (kind == KIND_TABLE && dw_idx == IFS_CNT_W'(PAIR)) begin
                beats = IFS_BEAT_W'(PAIR);
            end
        end
    end

endmodule

// File: rtl/ifs_assembler.sv
module ifs_assembler #(
    parameter int DW  = 32,
    parameter int NDW = 4,
    parameter int IW  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap,
    input  logic [IW-1:0]     idx,
    input  logic [DW-1:0]     din,
    output logic [NDW*DW-1:0] flat
);

    for (genvar g = 0; g < NDW; g++) begin : g_slot
        logic [DW-1:0] slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (clr) begin
                slot_q <= '0;
            end else if (cap && idx == IW'(g)) begin
                slot_q <= din;
            end
        end

        assign flat[g*DW +: DW] = slot_q;
    end

    AST_CAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cap |-> idx < IW'(NDW)); // R4

    AST_CLR_NOT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !cap); // R9

endmodule

// File: rtl/instr_fetch_seq.sv
module instr_fetch_seq
    import ifs_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_burst_en,
    input  logic                     cfg_prefetch_en,
    input  logic                     cfg_manual_start,
    input  logic                     ptr_wr_en,
    input  logic [AW-1:0]            ptr_wr_data,
    input  logic                     start_set,
    output logic                     bus_req,
    input  logic                     bus_gnt,
    output logic [AW-1:0]            bus_addr,
    input  logic                     bus_rd_valid,
    input  logic [DW-1:0]            bus_rd_data,
    output logic                     ins_valid,
    input  logic                     ins_ready,
    output logic [IFS_CNT_W-1:0]     ins_len,
    output logic [IFS_MAX_DW*DW-1:0] ins_data
);

    localparam int NDW  = IFS_MAX_DW;
    localparam int STEP = DW / 8;

    ifs_state_e                state_q, state_d;
    logic [IFS_CNT_W-1:0]      dw_idx_q;
    logic [IFS_BEAT_W-1:0]     beats_left_q;
    ifs_kind_e                 kind_q;
    logic                      running;
    logic [AW-1:0]             ptr;
    logic                      burst_mode;
    logic                      beat;
    logic                      last_beat;
    logic                      instr_done;
    logic                      start_instr;
    logic [IFS_BEAT_W-1:0]     plan_beats;
    logic [IFS_CNT_W-1:0]      plan_total;

    assign burst_mode  = cfg_burst_en & ~cfg_prefetch_en;
    assign beat        = (state_q == ST_XFER) && bus_rd_valid;
    assign last_beat   = beat && (beats_left_q == IFS_BEAT_W'(1));
    assign instr_done  = last_beat && (dw_idx_q != '0)
                         && (IFS_CNT_W'(dw_idx_q + 1'b1) == plan_total);
    assign start_instr = ((state_q == ST_IDLE) && running)
                         || ((state_q == ST_PRESENT) && ins_ready);

    ifs_start_ctrl #(
        .AW   (AW),
        .STEP (STEP)
    ) u_start (
        .clk         (clk),
        .rst_n       (rst_n),
        .manual_mode (cfg_manual_start),
        .wr_en       (ptr_wr_en),
        .wr_addr     (ptr_wr_data),
        .start_pulse (start_set),
        .advance     (beat),
        .ptr         (ptr),
        .running     (running)
    );

    ifs_burst_plan #(
        .PAIR (2)
    ) u_plan (
        .burst_mode (burst_mode),
        .dw_idx     (dw_idx_q),
        .kind       (kind_q),
        .beats      (plan_beats),
        .total      (plan_total)
    );

    ifs_assembler #(
        .DW  (DW),
        .NDW (NDW),
        .IW  (IFS_CNT_W)
    ) u_asm (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_instr),
        .cap   (beat),
        .idx   (dw_idx_q),
        .din   (bus_rd_data),
        .flat  (ins_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (running)   state_d = ST_REQ;
            ST_REQ:     if (bus_gnt)   state_d = ST_XFER;
            ST_XFER:    if (last_beat) state_d = instr_done ? ST_PRESENT : ST_GAP;
            ST_GAP:                    state_d = ST_REQ;
            ST_PRESENT: if (ins_ready) state_d = ST_REQ;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // Word index, beats left in the ownership, class of the instruction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dw_idx_q     <= '0;
            beats_left_q <= '0;
            kind_q       <= KIND_PLAIN;
        end else begin
            if (start_instr) begin
                dw_idx_q <= '0;
            end else if (beat) begin
                dw_idx_q <= dw_idx_q + 1'b1;
            end
            if ((state_q == ST_REQ) && bus_gnt) begin
                beats_left_q <= plan_beats;
            end else if (beat) begin
                beats_left_q <= beats_left_q - 1'b1;
            end
            if (beat && (dw_idx_q == '0)) begin
                kind_q <= ifs_kind_e'(bus_rd_data[DW-1 -: 2]);
            end
        end
    end

    // Outputs
    always_comb begin
        bus_req   = (state_q == ST_REQ) || (state_q == ST_XFER);
        ins_valid = (state_q == ST_PRESENT);
        bus_addr  = ptr;
        ins_len   = plan_total;
    end

    AST_REQ_UNTIL_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |=> bus_req); // R8

    AST_DROP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> !bus_req); // R8

    AST_PRESENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> !bus_req); // R9

    AST_PRESENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && !ins_ready |=> ins_valid && $stable(ins_data) && $stable(ins_len)); // R9

    AST_FIRST_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQ) && bus_gnt && burst_mode && (dw_idx_q == '0)
        |=> beats_left_q == IFS_BEAT_W'(2)); // R3

    AST_SINGLE_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQ) && bus_gnt && !burst_mode
        |=> beats_left_q == IFS_BEAT_W'(1)); // R6

endmodule

// File: tb/tb_instr_fetch_seq.sv
module tb_instr_fetch_seq;

    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int NDW = 4;
    localparam int NV  = 10;

    // {burst, prefetch, class[1:0], stall, len[2:0], owners[3:0], beats per owner 4x2}
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 1'b0, 2'b00, 1'b0, 3'd2, 4'd1, 8'h02},
        {1'b1, 1'b0, 2'b01, 1'b1, 3'd3, 4'd2, 8'h06},
        {1'b1, 1'b0, 2'b10, 1'b0, 3'd3, 4'd2, 8'h06},
        {1'b1, 1'b0, 2'b11, 1'b1, 3'd4, 4'd2, 8'h0A},
        {1'b0, 1'b0, 2'b00, 1'b0, 3'd2, 4'd2, 8'h05},
        {1'b0, 1'b0, 2'b11, 1'b1, 3'd4, 4'd4, 8'h55},
        {1'b1, 1'b1, 2'b11, 1'b0, 3'd4, 4'd4, 8'h55},
        {1'b1, 1'b1, 2'b01, 1'b1, 3'd3, 4'd3, 8'h15},
        {1'b0, 1'b1, 2'b10, 1'b0, 3'd3, 4'd3, 8'h15},
        {1'b0, 1'b0, 2'b01, 1'b0, 3'd3, 4'd3, 8'h15}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_burst_en, cfg_prefetch_en, cfg_manual_start;
    logic              ptr_wr_en;
    logic [AW-1:0]     ptr_wr_data;
    logic              start_set;
    logic              bus_req, bus_gnt, bus_rd_valid;
    logic [AW-1:0]     bus_addr;
    logic [DW-1:0]     bus_rd_data;
    logic              ins_valid, ins_ready;
    logic [2:0]        ins_len;
    logic [NDW*DW-1:0] ins_data;

    always #10 clk = ~clk;

    instr_fetch_seq #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_burst_en(cfg_burst_en), .cfg_prefetch_en(cfg_prefetch_en),
        .cfg_manual_start(cfg_manual_start),
        .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data), .start_set(start_set),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
        .bus_rd_valid(bus_rd_valid), .bus_rd_data(bus_rd_data),
        .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_len(ins_len), .ins_data(ins_data)
    );

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    logic [AW-1:0] exp_base = '0;
    logic [1:0]    cur_kind = 2'b00;
    int            gnt_lat  = 0;
    bit            stall_en = 1'b0;
    logic          mon_clr  = 1'b1;

    int            own_cnt, cur_beats, beat_n, addr_err;
    int            own_len [4];
    logic          prev_req;
    logic [AW-1:0] prev_addr;

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        logic [1:0] top;
        top = (a == exp_base) ? cur_kind : 2'b01;
        return {top, a[29:0] ^ 30'h2AAA5555};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Memory-side responder
    initial begin
        int  wait_ctr;
        bit  tog;
        wait_ctr     = 0;
        tog          = 1'b0;
        bus_gnt      = 1'b0;
        bus_rd_valid = 1'b0;
        bus_rd_data  = '0;
        forever begin
            @(negedge clk);
            if (!bus_req) begin
                bus_gnt      = 1'b0;
                bus_rd_valid = 1'b0;
                wait_ctr     = 0;
            end else if (!bus_gnt) begin
                if (wait_ctr >= gnt_lat) begin
                    bus_gnt = 1'b1;
                    tog     = 1'b0;
                end else begin
                    wait_ctr++;
                end
                bus_rd_valid = 1'b0;
            end else begin
                tog          = stall_en ? ~tog : 1'b1;
                bus_rd_valid = tog;
            end
            bus_rd_data = mem_word(bus_addr);
        end
    end

    // Ownership and address monitor, just after each rising edge
    initial begin
        prev_req  = 1'b0;
        prev_addr = '0;
        own_cnt   = 0;
        cur_beats = 0;
        beat_n    = 0;
        addr_err  = 0;
        forever begin
            @(posedge clk);
            #1;
            if (mon_clr) begin
                own_cnt   = 0;
                cur_beats = 0;
                beat_n    = 0;
                addr_err  = 0;
                for (int k = 0; k < 4; k++) own_len[k] = 0;
                prev_req  = 1'b0;
            end else begin
                if (prev_req && bus_gnt && bus_rd_valid) begin
                    if (prev_addr != exp_base + AW'(4 * beat_n)) addr_err++;
                    beat_n++;
                    cur_beats++;
                end
                if (prev_req && !bus_req) begin
                    if (own_cnt < 4) own_len[own_cnt] = cur_beats;
                    own_cnt++;
                    cur_beats = 0;
                end
                prev_req = bus_req;
            end
            prev_addr = bus_addr;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R8 watchdog actual=hang expected=finish");
        finish_run();
    end

    task automatic do_reset();
        rst_n            = 1'b0;
        cfg_burst_en     = 1'b0;
        cfg_prefetch_en  = 1'b0;
        cfg_manual_start = 1'b0;
        ptr_wr_en        = 1'b0;
        ptr_wr_data      = '0;
        start_set        = 1'b0;
        ins_ready        = 1'b0;
        mon_clr          = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n   = 1'b1;
        mon_clr = 1'b0;
    endtask

    task automatic write_ptr(input logic [AW-1:0] a);
        @(negedge clk);
        ptr_wr_en   = 1'b1;
        ptr_wr_data = a;
        @(negedge clk);
        ptr_wr_en   = 1'b0;
    endtask

    task automatic wait_valid(input string req);
        int n;
        n = 0;
        while (!ins_valid && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(ins_valid, req, "ins_valid never rose", ins_valid, 1);
    endtask

    initial begin
        logic [19:0]   v;
        logic [DW-1:0] ew;
        logic [127:0]  snap;
        string         grp;
        bit            ok;

        // R11: reset state
        do_reset();
        chk(!bus_req, "R11", "bus_req after reset", bus_req, 0);
        chk(!ins_valid, "R11", "ins_valid after reset", ins_valid, 0);

        // Vector table: class, burst, prefetch, stall and grant latency mixes
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            do_reset();
            cfg_burst_en    = v[19];
            cfg_prefetch_en = v[18];
            cur_kind        = v[17:16];
            stall_en        = v[15];
            gnt_lat         = i % 3;
            exp_base        = 32'h0000_1000 + AW'(i * 256);
            grp = (v[19] && !v[18]) ? ((v[17:16] == 2'b00) ? "R3" : "R5") : "R6";
            write_ptr(exp_base);
            wait_valid("R9");
            chk(ins_len == v[14:12], "R4", "ins_len", ins_len, v[14:12]);
            for (int k = 0; k < NDW; k++) begin
                ew = (k < int'(v[14:12])) ? mem_word(exp_base + AW'(4 * k)) : '0;
                chk(ins_data[k*DW +: DW] == ew, "R9", $sformatf("slot %0d", k),
                    ins_data[k*DW +: DW], ew);
            end
            chk(own_cnt == int'(v[11:8]), grp, "ownership count", own_cnt, v[11:8]);
            for (int k = 0; k < 4; k++) begin
                if (k < int'(v[11:8])) begin
                    chk(own_len[k] == int'(v[2*k +: 2]), grp,
                        $sformatf("beats in ownership %0d", k), own_len[k], v[2*k +: 2]);
                end
            end
            chk(addr_err == 0, "R7", "beat address mismatches", addr_err, 0);
            chk(beat_n == int'(v[14:12]), "R8", "beats completed", beat_n, v[14:12]);
        end

        // R1: automatic start timing
        do_reset();
        cfg_burst_en = 1'b1;
        cur_kind     = 2'b00;
        stall_en     = 1'b0;
        gnt_lat      = 0;
        exp_base     = 32'h0000_3000;
        write_ptr(exp_base);
        chk(!bus_req, "R1", "bus_req after write edge", bus_req, 0);
        @(negedge clk);
        chk(bus_req, "R1", "bus_req one edge later", bus_req, 1);

        // R8: request held through a long grant wait
        do_reset();
        cfg_burst_en = 1'b1;
        cur_kind     = 2'b00;
        gnt_lat      = 4;
        exp_base     = 32'h0000_3400;
        write_ptr(exp_base);
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(bus_req && beat_n == 0, "R8", "waiting for grant",
                {bus_req, 8'(beat_n)}, {1'b1, 8'd0});
        end
        wait_valid("R8");
        chk(beat_n == 2 && own_cnt == 1, "R8", "beats after late grant", beat_n, 2);

        // R2: manual start
        do_reset();
        cfg_manual_start = 1'b1;
        cur_kind         = 2'b01;
        gnt_lat          = 1;
        exp_base         = 32'h0000_4000;
        write_ptr(exp_base);
        ok = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (bus_req) ok = 1'b0;
        end
        chk(ok, "R2", "no request before start pulse", !ok, 0);
        @(negedge clk);
        start_set = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
        chk(!bus_req, "R2", "bus_req after start edge", bus_req, 0);
        @(negedge clk);
        chk(bus_req, "R2", "bus_req one edge after start", bus_req, 1);
        wait_valid("R2");
        chk(addr_err == 0 && beat_n == 3, "R2", "fetch from loaded pointer", addr_err, 0);
        chk(own_cnt == 3, "R6", "single-beat ownerships", own_cnt, 3);

        // R9, R10, R7: consumer stall, pointer write while running, continuity
        do_reset();
        cfg_burst_en = 1'b1;
        cur_kind     = 2'b11;
        stall_en     = 1'b1;
        gnt_lat      = 1;
        exp_base     = 32'h0000_2000;
        write_ptr(exp_base);
        wait_valid("R9");
        snap = ins_data;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(ins_valid && !bus_req && ins_data == snap, "R9", "held while not ready",
                {ins_valid, bus_req}, 2'b10);
        end
        ins_ready = 1'b1;
        @(negedge clk);
        ins_ready = 1'b0;
        chk(!ins_valid, "R9", "ins_valid after accept", ins_valid, 0);
        @(negedge clk);
        chk(bus_req, "R9", "next fetch begins", bus_req, 1);
        write_ptr(32'hDEAD_0000);
        wait_valid("R10");
        ew = mem_word(exp_base + 32'd16);
        chk(ins_data[DW-1:0] == ew, "R10", "second instruction word 0", ins_data[DW-1:0], ew);
        chk(ins_len == 3'd3, "R4", "second instruction length", ins_len, 3);
        chk(addr_err == 0 && beat_n == 7, "R7", "addresses continue across instructions",
            addr_err, 0);

        finish_run();
    end

endmodule